// File: doc/BRIEF.md
# Selectable-Ratio Codec Clock Generator

This block runs on the codec's master clock, which comes from a crystal or from an external source. It derives every clock the codec needs from that one clock.

- A converter clock, given both as a one-cycle enable and as a registered divided clock.
- An auxiliary clock at half the master rate.
- A bit clock and a word clock for the serial port when the port is the clock master.

Three static select pins set the division. Two ratio pins give the master-clock-to-sample-rate ratio. A range pin picks either the normal sample-rate range or the low sample-rate range.

In the normal range the converter clock must run at 256 times the sample rate. The master clock is 256, 512, 768 or 1024 times the sample rate, so the prescaler divides by 1, 2, 3 or 4. In the low range the converter clock must run at 512 times the sample rate. The master clock is then 512 or 1024 times the sample rate, so the prescaler divides by 1 or 2.

One counter chain feeds all the serial clocks: a prescaler, then a frame counter that advances on each converter tick. The bit clock and the word clock are taken from this chain, so they stay phase-locked to each other and to the converter clock. When any select pin changes, every counter restarts synchronously from phase zero.

Top module: `codec_clk_gen`

## Requirements
- R1: While rst_ni is low, conv_en_o, conv_clk_o, aux_clk_o, bclk_o and lrck_o are all low.
- R2: With low_fs_i = 0, conv_en_o pulses once every D master cycles, where D = ratio_sel_i + 1. The ratio codes 0, 1, 2 and 3 stand for masters of 256, 512, 768 and 1024 times the sample rate.
- R3: With low_fs_i = 1, ratio_sel_i = 2'b01 (a master of 1024 times the sample rate) gives D = 2. Every other ratio code gives D = 1 (a master of 512 times the sample rate), and conv_en_o stays high.
- R4: Within each D-cycle converter period, conv_clk_o is high for the first floor(D/2) cycles and low for the rest. conv_en_o is high on the last cycle only. For D = 1, conv_clk_o stays low. For D = 3, the duty cycle is 1/3.
- R5: aux_clk_o toggles on every master cycle in every selection, which gives a clock at half the master rate.
- R6: In master mode the frame holds F converter ticks, where F = CONV_PER_FS_LO when low_fs_i = 0 and F = 2*CONV_PER_FS_LO when low_fs_i = 1. bclk_o completes exactly BITS_PER_FS periods per frame and changes only after a converter tick.
- R7: lrck_o is low for the first half of each frame and high for the second half. It changes only where bclk_o falls, or where bclk_o stays low.
- R8: With master_i = 0, bclk_o and lrck_o are held low. The converter and auxiliary clocks are not affected.
- R9: On the first clock edge where the select pins differ from their values at the previous edge, all counters restart. After that edge: aux_clk_o, bclk_o and lrck_o are low, conv_clk_o is high if the new D >= 2, and conv_en_o is high only if the new D = 1. The next conv_en_o pulse follows exactly D cycles after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_sel_i | input | 2 | Master-clock-to-sample-rate ratio code |
| low_fs_i | input | 1 | 1 selects the low sample-rate range |
| master_i | input | 1 | 1 drives the serial bit and word clocks |
| conv_en_o | output | 1 | Converter-clock enable, one master cycle wide |
| conv_clk_o | output | 1 | Registered divided converter clock |
| aux_clk_o | output | 1 | Auxiliary clock at half the master rate |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Serial word clock |

## Verification
The bench builds the block with CONV_PER_FS_LO = 32 and BITS_PER_FS = 8. A frame then takes 32 or 64 converter ticks instead of 256 or 512, but the tick-to-bit-clock ratios keep the same power-of-two structure. The bench can therefore step through several whole word-clock frames for every one of the six ratio codes and check bit-clock edges per frame at each frame boundary. Restarts are triggered in the middle of a frame with the word clock high, to show that no runt edge is left over from the old setting.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  localparam int unsigned DIV_W = 3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             hi_range;
  } ccg_cfg_t;

  // ratio code -> prescaler divisor; unlisted low-fs codes fall back to div 1
  function automatic ccg_cfg_t ccg_decode(input logic [1:0] ratio, input logic low_fs);
    ccg_cfg_t c;
    c.hi_range = low_fs;
    if (!low_fs) c.div = {1'b0, ratio} + 3'd1;
    else         c.div = (ratio == 2'b01) ? 3'd2 : 3'd1;
    return c;
  endfunction
endpackage

// File: rtl/ccg_sel_guard.sv
module ccg_sel_guard #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             restart_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  assign restart_o = (sel_i != sel_q);
endmodule

// File: rtl/ccg_prescaler.sv
module ccg_prescaler
  import codec_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             conv_en_o,
  output logic             conv_clk_o
);
  logic [DIV_W-1:0] pre_q, pre_d, last;

  assign last = div_i - 3'd1;

  always_comb begin
    if (restart_i)          pre_d = '0;
    else if (pre_q == last) pre_d = '0;
    else                    pre_d = pre_q + 3'd1;
  end

  assign tick_o = !restart_i && (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      conv_en_o  <= 1'b0;
      conv_clk_o <= 1'b0;
    end else begin
      pre_q      <= pre_d;
      conv_en_o  <= (pre_d == last);
      conv_clk_o <= (pre_d < (div_i >> 1));
    end
  end

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (pre_q < div_i));
  assert_restart_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0));
  assert_clk_low_at_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |-> !conv_clk_o);
endmodule

// File: rtl/ccg_frame_counter.sv
module ccg_frame_counter #(
  parameter int unsigned CONV_PER_FS_LO = 256,
  parameter int unsigned BITS_PER_FS    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic hi_range_i,
  input  logic master_i,
  output logic bclk_o,
  output logic lrck_o
);
  localparam int unsigned FRAME_HI = 2 * CONV_PER_FS_LO;
  localparam int unsigned CNT_W    = $clog2(FRAME_HI);
  localparam int unsigned B_LO     = $clog2(CONV_PER_FS_LO / BITS_PER_FS) - 1;
  localparam int unsigned L_LO     = $clog2(CONV_PER_FS_LO) - 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(CONV_PER_FS_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(FRAME_HI - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             bclk_d, lrck_d;

  assign last = hi_range_i ? LAST_HI : LAST_LO;

  always_comb begin
    if (restart_i)   cnt_d = '0;
    else if (tick_i) cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  // tap positions move up one bit in the low-fs range
  assign bclk_d = master_i & (hi_range_i ? cnt_d[B_LO+1] : cnt_d[B_LO]);
  assign lrck_d = master_i & (hi_range_i ? cnt_d[L_LO+1] : cnt_d[L_LO]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
      lrck_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_o <= bclk_d;
      lrck_o <= lrck_d;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (cnt_q <= last));
endmodule

// File: rtl/ccg_aux_div.sv
module ccg_aux_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic aux_clk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        aux_clk_o <= 1'b0;
    else if (restart_i) aux_clk_o <= 1'b0;
    else                aux_clk_o <= ~aux_clk_o;
  end
endmodule

// File: rtl/codec_clk_gen.sv
module codec_clk_gen
  import codec_clk_pkg::*;
#(
  parameter int unsigned CONV_PER_FS_LO = 256,
  parameter int unsigned BITS_PER_FS    = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ratio_sel_i,
  input  logic       low_fs_i,
  input  logic       master_i,
  output logic       conv_en_o,
  output logic       conv_clk_o,
  output logic       aux_clk_o,
  output logic       bclk_o,
  output logic       lrck_o
);
  ccg_cfg_t cfg;
  logic     restart, tick;

  assign cfg = ccg_decode(ratio_sel_i, low_fs_i);

  ccg_sel_guard #(.SEL_W(3)) u_guard (
    .clk_i, .rst_ni,
    .sel_i    ({low_fs_i, ratio_sel_i}),
    .restart_o(restart)
  );

  ccg_prescaler u_pre (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .div_i     (cfg.div),
    .tick_o    (tick),
    .conv_en_o,
    .conv_clk_o
  );

  ccg_frame_counter #(
    .CONV_PER_FS_LO(CONV_PER_FS_LO),
    .BITS_PER_FS   (BITS_PER_FS)
  ) u_frame (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .tick_i    (tick),
    .hi_range_i(cfg.hi_range),
    .master_i,
    .bclk_o,
    .lrck_o
  );

  ccg_aux_div u_aux (
    .clk_i, .rst_ni,
    .restart_i(restart),
    .aux_clk_o
  );

  // checker-only history flags
  logic [1:0] arm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= {arm_q[0], 1'b1};
  end

  assert_aux_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[0] && !$past(restart)) |-> (aux_clk_o != $past(aux_clk_o)));
  assert_bclk_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[1] && !$stable(bclk_o) && !$past(restart) && $past(master_i) && $past(master_i, 2))
      |-> $past(conv_en_o));
  assert_lrck_on_bclk_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[1] && !$stable(lrck_o) && $past(master_i) && $past(master_i, 2)) |-> !bclk_o);
  assert_slave_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[0] && !$past(master_i)) |-> (!bclk_o && !lrck_o));
  assert_restart_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q[0] && $past(restart)) |-> (!aux_clk_o && !bclk_o && !lrck_o));
endmodule

// File: tb/tb_codec_clk_gen.sv
module tb_codec_clk_gen;
  localparam int unsigned LO   = 32;
  localparam int unsigned BITS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio = 2'b00;
  logic       low_fs = 1'b0;
  logic       master = 1'b1;
  logic       conv_en, conv_clk, aux_clk, bclk, lrck;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  codec_clk_gen #(.CONV_PER_FS_LO(LO), .BITS_PER_FS(BITS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_sel_i(ratio), .low_fs_i(low_fs),
    .master_i(master), .conv_en_o(conv_en), .conv_clk_o(conv_clk),
    .aux_clk_o(aux_clk), .bclk_o(bclk), .lrck_o(lrck)
  );

  // reference model built from the requirement text
  int   m_pre, m_tick;
  logic [2:0] m_sel;
  logic e_en, e_clk, e_aux, e_bclk, e_lrck;

  function automatic int div_of(input logic [1:0] r, input logic lf);
    if (!lf) return int'(r) + 1;
    return (r == 2'b01) ? 2 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_tick = 0; m_sel = 3'b000;
      e_en = 0; e_clk = 0; e_aux = 0; e_bclk = 0; e_lrck = 0;
    end else begin
      int d, fr, half_bit, np, nt;
      bit rs;
      d  = div_of(ratio, low_fs);
      fr = low_fs ? 2 * LO : LO;
      half_bit = fr / (2 * BITS);
      rs = ({low_fs, ratio} != m_sel);
      m_sel = {low_fs, ratio};
      if (rs) begin np = 0; nt = 0; end
      else begin
        np = (m_pre == d - 1) ? 0 : m_pre + 1;
        nt = (m_pre == d - 1) ? ((m_tick == fr - 1) ? 0 : m_tick + 1) : m_tick;
      end
      m_pre = np; m_tick = nt;
      e_en   = (np == d - 1);
      e_clk  = (np < d / 2);
      e_aux  = rs ? 1'b0 : ~e_aux;
      e_bclk = master && (((nt / half_bit) % 2) == 1);
      e_lrck = master && (nt >= fr / 2);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compares every output for n cycles; also counts bclk rises per word frame
  task automatic run_cmp(input int n, input string en_tag);
    int  rises = 0;
    bit  seen = 0;
    logic pb = bclk, pl = lrck;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(en_tag, "conv_en", conv_en, e_en);
      chk("R4", "conv_clk", conv_clk, e_clk);
      chk("R5", "aux_clk", aux_clk, e_aux);
      chk("R6", "bclk", bclk, e_bclk);
      chk("R7", "lrck", lrck, e_lrck);
      if (bclk && !pb) rises++;
      if (lrck && !pl) begin
        if (seen) chk("R6", "bclk periods per frame", rises, BITS);
        seen = 1; rises = 0;
      end
      pb = bclk; pl = lrck;
    end
  endtask

  task automatic count_en(input int d, input string tag);
    int cnt = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (conv_en) cnt++;
    end
    chk(tag, "conv_en pulses in 24 cycles", cnt, 24 / d);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "conv_en in reset", conv_en, 0);
    chk("R1", "conv_clk in reset", conv_clk, 0);
    chk("R1", "aux_clk in reset", aux_clk, 0);
    chk("R1", "bclk in reset", bclk, 0);
    chk("R1", "lrck in reset", lrck, 0);
  endtask

  task automatic t_low(input logic [1:0] r);
    @(negedge clk); low_fs = 0; ratio = r; master = 1;
    count_en(int'(r) + 1, "R2");
    run_cmp(3 * LO * (int'(r) + 1) + 8, "R2");
  endtask

  task automatic t_high(input logic [1:0] r);
    @(negedge clk); low_fs = 1; ratio = r; master = 1;
    count_en(div_of(r, 1'b1), "R3");
    run_cmp(3 * 2 * LO * div_of(r, 1'b1) + 8, "R3");
  endtask

  task automatic t_slave;
    int hi_cnt = 0;
    int en_cnt = 0;
    @(negedge clk); low_fs = 0; ratio = 2'b01; master = 0;
    for (int i = 0; i < 2 * LO * 2; i++) begin
      @(negedge clk);
      if (bclk || lrck) hi_cnt++;
      if (conv_en) en_cnt++;
    end
    chk("R8", "serial clock highs in slave", hi_cnt, 0);
    chk("R8", "conv_en pulses in slave", en_cnt, 2 * LO);
    run_cmp(40, "R8");
    @(negedge clk); master = 1;
  endtask

  task automatic t_restart(input logic [1:0] r_new);
    int guard = 0;
    @(negedge clk); low_fs = 0; ratio = 2'b11; master = 1;
    while (!(lrck && bclk) && guard < 2000) begin @(negedge clk); guard++; end
    chk("R9", "reached lrck and bclk high before switch", int'(lrck && bclk), 1);
    ratio = r_new;
    @(negedge clk);
    chk("R9", "aux after restart", aux_clk, 0);
    chk("R9", "bclk after restart", bclk, 0);
    chk("R9", "lrck after restart", lrck, 0);
    chk("R9", "conv_clk after restart", conv_clk, (int'(r_new) + 1 >= 2) ? 1 : 0);
    chk("R9", "conv_en after restart", conv_en, (r_new == 2'b00) ? 1 : 0);
    for (int k = 1; k < int'(r_new) + 1; k++) begin
      @(negedge clk);
      chk("R9", "conv_en before first pulse", conv_en, (k == int'(r_new)) ? 1 : 0);
    end
    run_cmp(2 * LO * (int'(r_new) + 1), "R2");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    low_fs = 0; ratio = 2'b10; master = 1;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    run_cmp(20, "R2");
    for (int r = 0; r < 4; r++) t_low(2'(r));
    for (int r = 0; r < 4; r++) t_high(2'(r));
    t_slave();
    t_restart(2'b10);
    t_restart(2'b00);
    t_restart(2'b01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule